// File: doc/BRIEF.md
# Dual-Compare PWM Timer Channel

This block is one channel of an up-counting timer with two value registers, A and B. Each register can act as a comparator or as a capture latch. In comparator mode, register B sets the period: when the counter reaches it, the counter returns to zero. Register A sets the duty point. Together the two registers produce periodic interrupts and a pulse-width-modulated output pin.

The counter advances by one on each clock edge where both the count-clock enable and the run bit are high. An optional double buffer holds the compare values actually in use. The buffer is reloaded from the written registers only at a period boundary or on a restart pulse, so software can change the period and duty without glitches. In capture mode, a rising edge on the capture input stores the current count in the register. Each register raises a sticky flag, which is cleared by writing a one. The flags, each gated by its own enable, are combined into a single interrupt line.

Top module: `pwm_cc_timer`

## Requirements
- R1: After reset the counter, both registers, both buffers and both flags are 0, the interrupt output is 0, and the timer output is 1.
- R2: The counter advances only on clock edges where `clk_en` and `run` are both 1. Otherwise it keeps its value.
- R3: With B in comparator mode (`b_cap_mode`=0), a tick at which the counter equals the B value returns the counter to 0 and sets `flag_b`. Starting from 0, this happens on tick B+1. The range is 0 to 65535.
- R4: With A in comparator mode (`a_cap_mode`=0), a tick at which the counter equals the A value sets `flag_a` and leaves the counting unchanged. Starting from 0, this happens on tick A+1.
- R5: The timer output is set to 1 by a B match or a restart, and cleared to 0 by an A match. A B match wins when both occur on the same tick, so A ≥ B keeps the output high. The output is forced to 0 while either register is in capture mode.
- R6: With `buf_en`=0, a written value is used for comparison from the next tick onward.
- R7: With `buf_en`=1, comparisons use buffer copies. The buffers are loaded from the registers only on a B match or a `restart` pulse.
- R8: With a mode bit at 1 (capture), a rising edge on `cap_in` copies the counter into that register and sets its flag. That register then produces no compare events.
- R9: The flags stay set until cleared by a 1 in `flag_clr`. Bit 0 clears A and bit 1 clears B. A set event in the same cycle wins over the clear.
- R10: `irq` is 1 exactly when (`flag_a` and `ie_a`) or (`flag_b` and `ie_b`).
- R11: A `restart` pulse clears the counter to 0 and loads both buffers, whatever the run state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_en | input | 1 | Count clock enable |
| run | input | 1 | Counting enabled; 0 holds the counter |
| restart | input | 1 | Pulse: counter to 0, buffers reloaded |
| buf_en | input | 1 | Compare double buffer enable |
| a_wr | input | 1 | Write strobe for register A |
| a_wdata | input | CW | Write data for register A |
| b_wr | input | 1 | Write strobe for register B |
| b_wdata | input | CW | Write data for register B |
| a_cap_mode | input | 1 | 1 = register A in capture mode |
| b_cap_mode | input | 1 | 1 = register B in capture mode |
| cap_in | input | 1 | Capture trigger, rising edge active |
| ie_a | input | 1 | Interrupt enable for flag A |
| ie_b | input | 1 | Interrupt enable for flag B |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 flag A, bit 1 flag B |
| cnt | output | CW | Current counter value |
| a_val | output | CW | Register A contents |
| b_val | output | CW | Register B contents |
| flag_a | output | 1 | Sticky flag A |
| flag_b | output | 1 | Sticky flag B |
| irq | output | 1 | Combined interrupt |
| tout | output | 1 | PWM timer output |

## Verification
The bench targets the off-by-one edges of the period. It checks the count one tick before and exactly at the A and B matches. A design that compared against B+1 or cleared one tick late would show a wrong count or a missing flag there. It drives A equal to B, A above B, A of 0, B of 0 and B at the full 16-bit maximum. These catch a design that let an A match pull the output low on the reset tick, or that never wrapped. It also writes a new period mid-count with the buffer off and then on. A design that bypassed the buffer would wrap early, and one that never reloaded it would keep the old period. The capture checks confirm that a register in capture mode stores the count without firing compares, which would otherwise set flags or move the output.

// File: rtl/pwm_cc_timer.sv
module pwm_cc_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          run,
  input  logic          restart,
  input  logic          buf_en,
  input  logic          a_wr,
  input  logic [CW-1:0] a_wdata,
  input  logic          b_wr,
  input  logic [CW-1:0] b_wdata,
  input  logic          a_cap_mode,
  input  logic          b_cap_mode,
  input  logic          cap_in,
  input  logic          ie_a,
  input  logic          ie_b,
  input  logic [1:0]    flag_clr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] a_val,
  output logic [CW-1:0] b_val,
  output logic          flag_a,
  output logic          flag_b,
  output logic          irq,
  output logic          tout
);

  logic [CW-1:0] cnt_q, a_reg, b_reg, a_buf, b_buf;
  logic          fa_q, fb_q, tout_q, cap_d;
  logic          tick, cap_rise, hit_a, hit_b, cap_a, cap_b, reload;
  logic [CW-1:0] a_cmp, b_cmp;

  assign tick     = clk_en & run;
  assign a_cmp    = buf_en ? a_buf : a_reg;
  assign b_cmp    = buf_en ? b_buf : b_reg;
  assign hit_a    = tick & ~a_cap_mode & (cnt_q == a_cmp);
  assign hit_b    = tick & ~b_cap_mode & (cnt_q == b_cmp);
  assign cap_rise = cap_in & ~cap_d;
  assign cap_a    = cap_rise & a_cap_mode;
  assign cap_b    = cap_rise & b_cap_mode;
  assign reload   = restart | hit_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || hit_b) cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_reg <= '0;
      b_reg <= '0;
    end else begin
      if (cap_a)     a_reg <= cnt_q;
      else if (a_wr) a_reg <= a_wdata;
      if (cap_b)     b_reg <= cnt_q;
      else if (b_wr) b_reg <= b_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_buf <= '0;
      b_buf <= '0;
    end else if (reload) begin
      a_buf <= a_reg;
      b_buf <= b_reg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fa_q  <= 1'b0;
      fb_q  <= 1'b0;
      cap_d <= 1'b0;
    end else begin
      fa_q  <= (fa_q & ~flag_clr[0]) | hit_a | cap_a;
      fb_q  <= (fb_q & ~flag_clr[1]) | hit_b | cap_b;
      cap_d <= cap_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tout_q <= 1'b1;
    else if (restart || hit_b) tout_q <= 1'b1;
    else if (hit_a)           tout_q <= 1'b0;
  end

  assign cnt    = cnt_q;
  assign a_val  = a_reg;
  assign b_val  = b_reg;
  assign flag_a = fa_q;
  assign flag_b = fb_q;
  assign irq    = (fa_q & ie_a) | (fb_q & ie_b);
  assign tout   = tout_q & ~a_cap_mode & ~b_cap_mode;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(cnt_q));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hit_b && !restart) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && !restart) |=> (cnt_q == '0 && fb_q));

  p_alow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !hit_b && !restart) |=> !tout_q);

  p_bufhold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !hit_b) |=> ($stable(a_buf) && $stable(b_buf)));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> (a_reg == $past(cnt_q) && fa_q));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_q && !flag_clr[1]) |=> fb_q);

  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && tout_q));

endmodule

// File: tb/pwm_cc_timer_tb.sv
module pwm_cc_timer_tb;
  localparam int CW = 16;
  localparam time TCLK = 10ns;

  logic clk = 0, rst_n = 0;
  logic clk_en = 1, run = 0, restart = 0, buf_en = 0;
  logic a_wr = 0, b_wr = 0;
  logic [CW-1:0] a_wdata = 0, b_wdata = 0;
  logic a_cap_mode = 0, b_cap_mode = 0, cap_in = 0, ie_a = 0, ie_b = 0;
  logic [1:0] flag_clr = 0;
  logic [CW-1:0] cnt, a_val, b_val;
  logic flag_a, flag_b, irq, tout;

  int nvec = 0, nfail = 0;

  always #(TCLK/2) clk = ~clk;

  pwm_cc_timer #(.CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .run(run), .restart(restart),
    .buf_en(buf_en), .a_wr(a_wr), .a_wdata(a_wdata), .b_wr(b_wr), .b_wdata(b_wdata),
    .a_cap_mode(a_cap_mode), .b_cap_mode(b_cap_mode), .cap_in(cap_in),
    .ie_a(ie_a), .ie_b(ie_b), .flag_clr(flag_clr), .cnt(cnt), .a_val(a_val),
    .b_val(b_val), .flag_a(flag_a), .flag_b(flag_b), .irq(irq), .tout(tout)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        be;
    logic [31:0] n;
    logic [15:0] ecnt;
    logic        etout;
    logic        efa;
    logic        efb;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{16'd2,   16'd5,     1'b0, 32'd3,   16'd3,   1'b0, 1'b1, 1'b0},
    '{16'd2,   16'd5,     1'b0, 32'd2,   16'd2,   1'b1, 1'b0, 1'b0},
    '{16'd2,   16'd5,     1'b1, 32'd6,   16'd0,   1'b1, 1'b1, 1'b1},
    '{16'd2,   16'd5,     1'b0, 32'd8,   16'd2,   1'b1, 1'b1, 1'b1},
    '{16'd7,   16'd5,     1'b0, 32'd6,   16'd0,   1'b1, 1'b0, 1'b1},
    '{16'd7,   16'd5,     1'b1, 32'd4,   16'd4,   1'b1, 1'b0, 1'b0},
    '{16'd5,   16'd5,     1'b0, 32'd6,   16'd0,   1'b1, 1'b1, 1'b1},
    '{16'd5,   16'd5,     1'b1, 32'd5,   16'd5,   1'b1, 1'b0, 1'b0},
    '{16'd0,   16'd3,     1'b0, 32'd1,   16'd1,   1'b0, 1'b1, 1'b0},
    '{16'd0,   16'd0,     1'b0, 32'd3,   16'd0,   1'b1, 1'b1, 1'b1},
    '{16'd100, 16'd65535, 1'b1, 32'd101, 16'd101, 1'b0, 1'b1, 1'b0},
    '{16'd3,   16'd9,     1'b0, 32'd25,  16'd5,   1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    @(negedge clk) run = 1;
    repeat (n) @(negedge clk);
    run = 0;
  endtask

  task automatic wr_a(input logic [CW-1:0] v);
    @(negedge clk) begin a_wr = 1; a_wdata = v; end
    @(negedge clk) a_wr = 0;
  endtask

  task automatic wr_b(input logic [CW-1:0] v);
    @(negedge clk) begin b_wr = 1; b_wdata = v; end
    @(negedge clk) b_wr = 0;
  endtask

  task automatic pulse_restart();
    @(negedge clk) restart = 1;
    @(negedge clk) restart = 0;
  endtask

  task automatic clear(input logic [1:0] m);
    @(negedge clk) flag_clr = m;
    @(negedge clk) flag_clr = 0;
  endtask

  task automatic pulse_cap();
    @(negedge clk) cap_in = 1;
    @(negedge clk) cap_in = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cnt", cnt, 0);
    chk("R1 tout", tout, 1);
    chk("R1 flag_a", flag_a, 0);
    chk("R1 flag_b", flag_b, 0);
    chk("R1 irq", irq, 0);
    chk("R1 a_val", a_val, 0);
    @(negedge clk) rst_n = 1;

    for (int i = 0; i < 12; i++) begin
      buf_en = VEC[i].be;
      wr_a(VEC[i].a);
      wr_b(VEC[i].b);
      pulse_restart();
      clear(2'b11);
      ticks(int'(VEC[i].n));
      chk("R3 cnt", cnt, VEC[i].ecnt);
      chk("R5 tout", tout, VEC[i].etout);
      chk("R4 flag_a", flag_a, VEC[i].efa);
      chk("R3 flag_b", flag_b, VEC[i].efb);
    end

    buf_en = 0;
    wr_a(2); wr_b(50); pulse_restart();
    ticks(10);
    chk("R6 cnt before write", cnt, 10);
    clear(2'b11);
    wr_b(12);
    ticks(3);
    chk("R6 unbuffered wrap cnt", cnt, 0);
    chk("R6 unbuffered flag_b", flag_b, 1);

    buf_en = 1;
    wr_b(50); pulse_restart();
    ticks(10);
    clear(2'b11);
    wr_b(12);
    ticks(3);
    chk("R7 buffered no early wrap", cnt, 13);
    chk("R7 buffered flag_b", flag_b, 0);
    ticks(38);
    chk("R7 old period wrap cnt", cnt, 0);
    chk("R7 old period flag_b", flag_b, 1);
    clear(2'b11);
    ticks(12);
    chk("R7 new period not yet", cnt, 12);
    ticks(1);
    chk("R7 new period wrap", cnt, 0);
    chk("R7 new period flag_b", flag_b, 1);
    buf_en = 0;

    a_cap_mode = 1;
    wr_b(20); pulse_restart(); clear(2'b11);
    ticks(7);
    chk("R5 tout low in capture", tout, 0);
    pulse_cap();
    chk("R8 capture a_val", a_val, 7);
    chk("R8 capture flag_a", flag_a, 1);
    chk("R8 b untouched", b_val, 20);
    clear(2'b11);
    ticks(10);
    chk("R8 no compare cnt", cnt, 17);
    chk("R8 no compare flag_a", flag_a, 0);
    a_cap_mode = 0;

    b_cap_mode = 1;
    wr_b(5); pulse_restart(); clear(2'b11);
    ticks(30);
    chk("R8 b capture free run", cnt, 30);
    chk("R8 b no compare flag", flag_b, 0);
    pulse_cap();
    chk("R8 b captured", b_val, 30);
    chk("R8 b capture flag", flag_b, 1);
    b_cap_mode = 0;
    a_cap_mode = 1;
    pulse_cap();
    a_cap_mode = 0;
    chk("R9 flag_a set", flag_a, 1);
    clear(2'b01);
    chk("R9 clear A only", flag_a, 0);
    chk("R9 B stays", flag_b, 1);

    ie_a = 1; ie_b = 0;
    @(negedge clk);
    chk("R10 masked irq", irq, 0);
    ie_b = 1;
    @(negedge clk);
    chk("R10 enabled irq", irq, 1);
    clear(2'b10);
    chk("R10 irq after clear", irq, 0);
    ie_a = 0; ie_b = 0;

    wr_a(3); wr_b(40); pulse_restart();
    ticks(10);
    chk("R11 mid count", cnt, 10);
    chk("R11 tout low mid", tout, 0);
    pulse_restart();
    chk("R11 restart cnt", cnt, 0);
    chk("R11 restart tout", tout, 1);

    ticks(5);
    chk("R2 counting", cnt, 5);
    clk_en = 0;
    ticks(5);
    chk("R2 clk_en off holds", cnt, 5);
    clk_en = 1;
    repeat (5) @(negedge clk);
    chk("R2 run off holds", cnt, 5);

    summary();
    $finish;
  end
endmodule